// File: doc/BRIEF.md
# DMA Channel Address Generator with Selectable Stride

This block keeps the source and destination addresses of one DMA channel. When the transfer engine signals that a transfer unit has moved, each address steps up, steps down or stays where it is. Each address has its own direction control and its own stride code. The stride code picks the bit of the address counter at which counting starts. With this, a pointer can walk a buffer one element at a time, or it can jump by larger power-of-two blocks such as 256 bytes.

Starting the channel loads both pointers from their initial values. After that, each step strobe moves both pointers at the next rising clock edge. The arithmetic is modulo 2^32. The block does not touch the bus and does not move any data.

Top module: `dma_addr_counter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `src_addr` and `dst_addr` read 0 until the first load.
- R2: A rising edge with `start` high copies `src_init` and `dst_init` into `src_addr` and `dst_addr`. `start` takes priority over `step` in the same cycle.
- R3: A rising edge with both `start` and `step` low leaves both addresses unchanged.
- R4: Direction codes are 2'b00 = add the stride, 2'b01 = subtract the stride, 2'b10 and 2'b11 = fixed. A fixed pointer keeps its value on a step.
- R5: With stride code 3'b000, the stride is set by `xfer_size`: 2'b00 gives 1 byte, 2'b01 gives 2 bytes, 2'b10 gives 4 bytes and 2'b11 gives 4 bytes.
- R6: A nonzero stride code k gives a stride of 1 shifted left by 4*k. For example, 3'b001 gives 0x10, 3'b010 gives 0x100 and 3'b111 gives 0x1000_0000.
- R7: The source and destination pointers use only their own direction and stride code. The transfer size is shared between them.
- R8: Address arithmetic wraps modulo 2^32, and no flag is raised on a wrap.
- R9: A 2-byte decrementing destination with code 3'b000 that starts at 0xB000_0000 reads 0xAFFF_FFFE, 0xAFFF_FFFC and 0xAFFF_FFFA after three steps. A decrementing source with code 3'b010 that starts at 0xA000_0000 reads 0x9FFF_FF00, 0x9FFF_FE00 and 0x9FFF_FD00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Channel start: load both initial addresses |
| step | input | 1 | One transfer unit completed: advance both pointers |
| src_init | input | 32 | Initial source address |
| dst_init | input | 32 | Initial destination address |
| src_dir | input | 2 | Source direction code |
| dst_dir | input | 2 | Destination direction code |
| src_mode | input | 3 | Source stride code |
| dst_mode | input | 3 | Destination stride code |
| xfer_size | input | 2 | Transfer unit size code |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
The bench targets the following corner cases:
- **Priority of start over step.** A design that lets the step win would load and then skip ahead by one stride.
- **Reserved size code 2'b11.** A mis-decoded stride here shows up as a wrong byte step.
- **Top stride code.** Code 3'b111 reaches bit 28; a truncated shift would give zero motion.
- **Wrap at both ends of the address space.** This catches saturating or flag-raising arithmetic.
- **Mixed source and destination settings.** Random runs with different settings per pointer expose any crossed controls.
- **Fixed direction codes.** These show whether a held pointer drifts on a step.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    typedef enum logic [1:0] {
        DIR_UP    = 2'b00,
        DIR_DOWN  = 2'b01,
        DIR_HOLD  = 2'b10,
        DIR_HOLDX = 2'b11
    } ptr_dir_e;

    typedef enum logic [1:0] {
        UNIT_B8  = 2'b00,
        UNIT_B16 = 2'b01,
        UNIT_B32 = 2'b10,
        UNIT_RSV = 2'b11
    } unit_size_e;

    // log2 of the byte count of one transfer unit; the reserved code acts as a word
    function automatic logic [1:0] unit_log2(input logic [1:0] size);
        case (size)
            UNIT_B8:  unit_log2 = 2'd0;
            UNIT_B16: unit_log2 = 2'd1;
            default:  unit_log2 = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dma_stride_sel.sv
module dma_stride_sel #(
    parameter int ADDR_W = 32,
    parameter int MODE_W = 3,
    parameter int GRAN   = 4
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [1:0]        size_i,
    output logic [ADDR_W-1:0] stride_o
);
    import dma_addr_pkg::*;

    localparam int NUM_CODES = 1 << MODE_W;

    logic [ADDR_W-1:0] stride_tab [NUM_CODES];
    logic [ADDR_W-1:0] unit_stride;

    // code 0 follows the transfer unit; every other code is a fixed power of two
    assign unit_stride   = ADDR_W'(1) << unit_log2(size_i);
    assign stride_tab[0] = unit_stride;

    for (genvar g = 1; g < NUM_CODES; g++) begin : g_code
        assign stride_tab[g] = ADDR_W'(1) << (g * GRAN);
    end

    assign stride_o = stride_tab[mode_i];

endmodule

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [1:0]        dir_i,
    input  logic [ADDR_W-1:0] init_i,
    input  logic [ADDR_W-1:0] stride_i,
    output logic [ADDR_W-1:0] addr_o
);
    import dma_addr_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ptr_state_t;

    ptr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.addr = init_i;
        end else if (step_i) begin
            case (ptr_dir_e'(dir_i))
                DIR_UP:   state_d.addr = state_q.addr + stride_i;
                DIR_DOWN: state_d.addr = state_q.addr - stride_i;
                default:  state_d.addr = state_q.addr;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign addr_o = state_q.addr;

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(init_i));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(addr_o));

    // R4
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && dir_i[1]) |=> $stable(addr_o));

    // R8
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && dir_i == 2'b00) |=> addr_o == ADDR_W'($past(addr_o) + $past(stride_i)));

    // R8
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && dir_i == 2'b01) |=> addr_o == ADDR_W'($past(addr_o) - $past(stride_i)));

endmodule

// File: rtl/dma_addr_counter.sv
module dma_addr_counter #(
    parameter int ADDR_W = 32,
    parameter int MODE_W = 3,
    parameter int GRAN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [1:0]        src_dir,
    input  logic [1:0]        dst_dir,
    input  logic [MODE_W-1:0] src_mode,
    input  logic [MODE_W-1:0] dst_mode,
    input  logic [1:0]        xfer_size,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int NUM_PTR = 2;

    logic [ADDR_W-1:0] init_a   [NUM_PTR];
    logic [1:0]        dir_a    [NUM_PTR];
    logic [MODE_W-1:0] mode_a   [NUM_PTR];
    logic [ADDR_W-1:0] stride_a [NUM_PTR];
    logic [ADDR_W-1:0] addr_a   [NUM_PTR];

    // index 0 is the source pointer, index 1 the destination pointer
    assign init_a[0] = src_init;
    assign init_a[1] = dst_init;
    assign dir_a[0]  = src_dir;
    assign dir_a[1]  = dst_dir;
    assign mode_a[0] = src_mode;
    assign mode_a[1] = dst_mode;

    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        dma_stride_sel #(
            .ADDR_W (ADDR_W),
            .MODE_W (MODE_W),
            .GRAN   (GRAN)
        ) i_stride (
            .mode_i   (mode_a[p]),
            .size_i   (xfer_size),
            .stride_o (stride_a[p])
        );

        dma_ptr_reg #(
            .ADDR_W (ADDR_W)
        ) i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (start),
            .step_i   (step),
            .dir_i    (dir_a[p]),
            .init_i   (init_a[p]),
            .stride_i (stride_a[p]),
            .addr_o   (addr_a[p])
        );
    end

    assign src_addr = addr_a[0];
    assign dst_addr = addr_a[1];

endmodule

// File: tb/test_dma_addr_counter.sv
`timescale 1ns/1ps
module test_dma_addr_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        step = 1'b0;
    logic [31:0] src_init = '0;
    logic [31:0] dst_init = '0;
    logic [1:0]  src_dir = '0;
    logic [1:0]  dst_dir = '0;
    logic [2:0]  src_mode = '0;
    logic [2:0]  dst_mode = '0;
    logic [1:0]  xfer_size = '0;
    logic [31:0] src_addr, dst_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_src = '0;
    logic [31:0] exp_dst = '0;

    always #2.5 clk = ~clk;

    dma_addr_counter i_dma_addr_counter (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .src_init(src_init), .dst_init(dst_init),
        .src_dir(src_dir), .dst_dir(dst_dir),
        .src_mode(src_mode), .dst_mode(dst_mode),
        .xfer_size(xfer_size),
        .src_addr(src_addr), .dst_addr(dst_addr)
    );

    function automatic logic [31:0] stride_of(input logic [2:0] mode, input logic [1:0] size);
        if (mode != 3'd0) return 32'h1 << (4 * mode);
        case (size)
            2'b00:   return 32'd1;
            2'b01:   return 32'd2;
            default: return 32'd4;
        endcase
    endfunction

    function automatic logic [31:0] next_of(input logic [31:0] cur, input logic [1:0] dir,
                                            input logic [2:0] mode, input logic [1:0] size);
        case (dir)
            2'b00:   return cur + stride_of(mode, size);
            2'b01:   return cur - stride_of(mode, size);
            default: return cur;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs are already set after a falling edge; apply one rising edge, then compare
    task automatic tick(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            exp_src = '0; exp_dst = '0;
        end else if (start) begin
            exp_src = src_init; exp_dst = dst_init;
        end else if (step) begin
            exp_src = next_of(exp_src, src_dir, src_mode, xfer_size);
            exp_dst = next_of(exp_dst, dst_dir, dst_mode, xfer_size);
        end
        @(negedge clk);
        check({tag, " src"}, src_addr, exp_src);
        check({tag, " dst"}, dst_addr, exp_dst);
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d);
        start = 1'b1; step = 1'b0; src_init = s; dst_init = d;
        tick("R2 load");
        start = 1'b0;
    endtask

    task automatic set(input logic [1:0] sd, input logic [2:0] sm,
                       input logic [1:0] dd, input logic [2:0] dm, input logic [1:0] sz);
        src_dir = sd; src_mode = sm; dst_dir = dd; dst_mode = dm; xfer_size = sz;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        process::self().srandom(32'd1234);
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 src in reset", src_addr, 32'h0);
        check("R1 dst in reset", dst_addr, 32'h0);
        rst_n = 1'b1;
        tick("R1 after release");

        // R2: load, then load with step in the same cycle
        set(2'b00, 3'd0, 2'b00, 3'd0, 2'b10);
        load(32'h1234_5678, 32'h8765_4320);
        start = 1'b1; step = 1'b1; src_init = 32'h0000_1000; dst_init = 32'h0000_2000;
        tick("R2 start beats step");
        check("R2 src exact", src_addr, 32'h0000_1000);
        start = 1'b0; step = 1'b0;

        // R3: idle cycles hold
        src_init = 32'hDEAD_BEEF;
        tick("R3 idle");
        tick("R3 idle");

        // R4: fixed codes
        step = 1'b1;
        set(2'b10, 3'd2, 2'b11, 3'd7, 2'b01);
        tick("R4 fixed");
        check("R4 fixed src", src_addr, 32'h0000_1000);

        // R5: unit stride for every size code
        for (int sz = 0; sz < 4; sz++) begin
            set(2'b00, 3'd0, 2'b01, 3'd0, 2'(sz));
            tick("R5 size");
        end
        check("R5 src after sizes", src_addr, 32'h0000_100B);

        // R6: every nonzero stride code
        for (int m = 1; m < 8; m++) begin
            load(32'h4000_0000, 32'h4000_0000);
            step = 1'b1;
            set(2'b00, 3'(m), 2'b01, 3'(m), 2'b00);
            tick("R6 code");
            check("R6 src code", src_addr, 32'h4000_0000 + (32'h1 << (4 * m)));
        end

        // R8: wrap at both ends
        load(32'hFFFF_FFFF, 32'h0000_0000);
        step = 1'b1;
        set(2'b00, 3'd0, 2'b01, 3'd7, 2'b00);
        tick("R8 wrap");
        check("R8 src wrap up", src_addr, 32'h0000_0000);
        check("R8 dst wrap down", dst_addr, 32'hF000_0000);

        // R9: stated stepping sequences
        load(32'hA000_0000, 32'hB000_0000);
        step = 1'b1;
        set(2'b01, 3'd2, 2'b01, 3'd0, 2'b01);
        tick("R9 step1");
        check("R9 src 1", src_addr, 32'h9FFF_FF00);
        check("R9 dst 1", dst_addr, 32'hAFFF_FFFE);
        tick("R9 step2");
        check("R9 src 2", src_addr, 32'h9FFF_FE00);
        check("R9 dst 2", dst_addr, 32'hAFFF_FFFC);
        tick("R9 step3");
        check("R9 src 3", src_addr, 32'h9FFF_FD00);
        check("R9 dst 3", dst_addr, 32'hAFFF_FFFA);

        // R7: random mixed settings, independent per pointer
        for (int i = 0; i < 3000; i++) begin
            start = ($urandom_range(0, 15) == 0);
            step  = ($urandom_range(0, 3) != 0);
            src_init = $urandom; dst_init = $urandom;
            set(2'($urandom), 3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom));
            tick("R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule